// File: doc/BRIEF.md
# Peak-and-Hold Solenoid Current Sequencer

This block sequences the current profile of a solenoid valve that sits between a high-side and a low-side switch. A reference position event starts a programmable wait. The drive then runs a peak phase and a hold phase, followed by a clamp phase in which both switches are open and the coil current decays. An optional opening pulse can follow the first clamp, and it ends in a clamp of its own. The opening pulse is used to brake the armature so that it lands softly.

In the drive phases the block regulates current in closed loop from the edges of a single current comparator. An 8-bit reference code goes to the comparator's DAC. While the high-side switch is on, this code is the phase's upper limit, and the switch turns off once the comparator reports current above it. While the switch is off, the code is the lower limit, and the switch turns back on once the current falls below it. An overcurrent comparator aborts the drive into the clamp phase. All durations and limits come from a small write-only register port. The current phase code and the high-side state are brought out for monitoring logic.

Top module: `ph_solenoid_seq`

## Requirements
- R1: While reset is held, and until the first trigger, `phase` is 0 (idle), `hs_en_n` and `ls_en_n` are 1, `dac_code` is 0 and `hs_on` is 0.
- R2: A one-cycle `tdc_evt` in idle starts a profile only when control register 0 bit 0 (enable) is 1. With enable at 0 the block stays in idle.
- R3: The wait phase (code 1) lasts exactly D+1 cycles, where D is register 1.
- R4: Phases follow the order wait(1), peak(2), hold(3), clamp(4), idle(0). Peak lasts register 2 + 1 cycles, hold lasts register 3 + 1 cycles and clamp lasts register 4 + 1 cycles.
- R5: When control bit 1 (opening pulse) is set, the first clamp is followed by an opening phase (code 5) of register 5 + 1 cycles. A second clamp of register 4 + 1 cycles then follows before idle.
- R6: In a drive phase, a high-side switch that is on turns off when the synchronized current comparator is 1, and a switch that is off turns on when it is 0. `dac_code` is the phase's upper limit while the switch is on and its lower limit while it is off. The limit registers are 6 (peak), 7 (hold) and 8 (opening), with the upper limit in bits [7:0] and the lower limit in bits [15:8].
- R7: The high-side switch is on in the first cycle of peak and of the opening phase, and off in the first cycle of hold.
- R8: `ls_en_n` is 0 throughout every drive phase. `hs_en_n` is never 0 while `ls_en_n` is 1. Both are 1 in idle, in wait, and from the first cycle of clamp.
- R9: An overcurrent comparator input of 1 during a drive phase moves the block to clamp three clock edges after it is applied. It also cancels a pending opening pulse.
- R10: Both comparator inputs pass through two synchronizer flops. A change on the current comparator reaches `hs_en_n` on the third rising edge after it is applied, and not earlier.
- R11: `phase` carries the codes listed above, and `hs_on` is 1 exactly when `hs_en_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| tdc_evt | input | 1 | Reference position event, one cycle |
| cmp_cur | input | 1 | Current comparator, 1 when current is above `dac_code` |
| cmp_oc | input | 1 | Overcurrent comparator, 1 on overcurrent |
| hs_en_n | output | 1 | High-side switch enable, active low |
| ls_en_n | output | 1 | Low-side switch enable, active low |
| dac_code | output | 8 | Comparator reference code |
| phase | output | 3 | Current phase code |
| hs_on | output | 1 | High-side switch state for monitoring |

## Verification
The bench runs profiles with zero-length and long phases and counts each phase cycle by cycle. An off-by-one timer would shift those counts, and a wrong branch out of clamp would either skip or repeat the opening pulse. Directed tests step the current comparator one edge at a time. A missing synchronizer flop would move the high-side switch a cycle early, and a swapped upper/lower limit would show the wrong DAC code for the switch state. An overcurrent applied in hold must reach clamp and suppress the opening pulse; a design that only gated the switches would keep running the profile and still launch the opening pulse. A trigger with enable cleared must leave the block in idle.

// File: rtl/phs_pkg.sv
package phs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WAIT  = 3'd1,
    PH_PEAK  = 3'd2,
    PH_HOLD  = 3'd3,
    PH_CLAMP = 3'd4,
    PH_OPEN  = 3'd5
  } phase_e;

  // timer slots: wait, peak, hold, clamp, opening
  localparam int unsigned NTIM = 5;
  // limit slots: peak, hold, opening
  localparam int unsigned NTHR = 3;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_TIM0 = 1;
  localparam int unsigned A_THR0 = A_TIM0 + NTIM;
endpackage

// File: rtl/phs_sync.sv
module phs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 2'b00;
    else        q <= {q[0], 1'b1};
  end
  assign rst_sync_n = q[1];
endmodule

module phs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q[0] <= '0;
    else        q[0] <= din;
  end
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[s] <= '0;
      else        q[s] <= q[s-1];
    end
  end
  assign dout = q[STAGES-1];
endmodule

// File: rtl/phs_regs.sv
module phs_regs
  import phs_pkg::*;
#(
  parameter int unsigned TIME_W = 16,
  parameter int unsigned DAC_W  = 8,
  parameter int unsigned WR_W   = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [WR_W-1:0]                  wr_data,
  output logic                             en,
  output logic                             open_en,
  output logic [NTIM-1:0][TIME_W-1:0]      tim,
  output logic [NTHR-1:0][DAC_W-1:0]       thr_hi,
  output logic [NTHR-1:0][DAC_W-1:0]       thr_lo
);
  logic [1:0] ctrl_q;
  logic       ctrl_we;

  assign ctrl_we = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wr_data[1:0];
  end
  assign en      = ctrl_q[0];
  assign open_en = ctrl_q[1];

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    logic we;
    assign we = wr_en && (wr_addr == ADDR_W'(A_TIM0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tim[g] <= '0;
      else if (we) tim[g] <= wr_data[TIME_W-1:0];
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic we;
    assign we = wr_en && (wr_addr == ADDR_W'(A_THR0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_hi[g] <= '0;
        thr_lo[g] <= '0;
      end else if (we) begin
        thr_hi[g] <= wr_data[DAC_W-1:0];
        thr_lo[g] <= wr_data[2*DAC_W-1:DAC_W];
      end
    end
  end
endmodule

// File: rtl/phs_seq.sv
module phs_seq
  import phs_pkg::*;
#(
  parameter int unsigned TIME_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        open_en,
  input  logic                        trig,
  input  logic                        oc_s,
  input  logic [NTIM-1:0][TIME_W-1:0] tim,
  output phase_e                      phase_q,
  output phase_e                      phase_d
);
  logic [TIME_W-1:0] cnt_q, cnt_d, cur_len;
  logic              fault_q, fault_d, second_q, second_d;
  logic              done, drive;

  always_comb begin
    case (phase_q)
      PH_WAIT:  cur_len = tim[0];
      PH_PEAK:  cur_len = tim[1];
      PH_HOLD:  cur_len = tim[2];
      PH_CLAMP: cur_len = tim[3];
      PH_OPEN:  cur_len = tim[4];
      default:  cur_len = '0;
    endcase
  end

  assign done  = (cnt_q == cur_len);
  assign drive = (phase_q == PH_PEAK) || (phase_q == PH_HOLD) || (phase_q == PH_OPEN);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:  if (en && trig) phase_d = PH_WAIT;
      PH_WAIT:  if (done) phase_d = PH_PEAK;
      PH_PEAK:  if (oc_s) phase_d = PH_CLAMP; else if (done) phase_d = PH_HOLD;
      PH_HOLD:  if (oc_s || done) phase_d = PH_CLAMP;
      PH_OPEN:  if (oc_s || done) phase_d = PH_CLAMP;
      PH_CLAMP: if (done) phase_d = (open_en && !second_q && !fault_q) ? PH_OPEN : PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    if (phase_d != phase_q) cnt_d = '0;
    else if (done)          cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;

    if (phase_q == PH_IDLE)  fault_d = 1'b0;
    else if (drive && oc_s)  fault_d = 1'b1;
    else                     fault_d = fault_q;

    if (phase_q == PH_IDLE)       second_d = 1'b0;
    else if (phase_d == PH_OPEN)  second_d = 1'b1;
    else                          second_d = second_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      fault_q  <= 1'b0;
      second_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      fault_q  <= fault_d;
      second_q <= second_d;
    end
  end
endmodule

// File: rtl/phs_drive.sv
module phs_drive
  import phs_pkg::*;
#(
  parameter int unsigned DAC_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  phase_e                     phase_q,
  input  phase_e                     phase_d,
  input  logic                       cmp_s,
  input  logic [NTHR-1:0][DAC_W-1:0] thr_hi,
  input  logic [NTHR-1:0][DAC_W-1:0] thr_lo,
  output logic                       hs_q,
  output logic                       ls_q,
  output logic [DAC_W-1:0]           dac_q
);
  logic             hs_d, drive_d;
  logic [1:0]       idx;
  logic [DAC_W-1:0] dac_d;

  assign drive_d = (phase_d == PH_PEAK) || (phase_d == PH_HOLD) || (phase_d == PH_OPEN);

  always_comb begin
    case (phase_d)
      PH_HOLD: idx = 2'd1;
      PH_OPEN: idx = 2'd2;
      default: idx = 2'd0;
    endcase
  end

  always_comb begin
    if (!drive_d)                 hs_d = 1'b0;
    else if (phase_d != phase_q)  hs_d = (phase_d != PH_HOLD);
    else if (hs_q && cmp_s)       hs_d = 1'b0;
    else if (!hs_q && !cmp_s)     hs_d = 1'b1;
    else                          hs_d = hs_q;

    if (!drive_d)  dac_d = '0;
    else if (hs_d) dac_d = thr_hi[idx];
    else           dac_d = thr_lo[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
      dac_q <= '0;
    end else begin
      hs_q  <= hs_d;
      ls_q  <= drive_d;
      dac_q <= dac_d;
    end
  end
endmodule

// File: rtl/ph_solenoid_seq.sv
module ph_solenoid_seq
  import phs_pkg::*;
#(
  parameter int unsigned TIME_W = 16,
  parameter int unsigned DAC_W  = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned WR_W  = (TIME_W > 2*DAC_W) ? TIME_W : 2*DAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              tdc_evt,
  input  logic              cmp_cur,
  input  logic              cmp_oc,
  output logic              hs_en_n,
  output logic              ls_en_n,
  output logic [DAC_W-1:0]  dac_code,
  output logic [2:0]        phase,
  output logic              hs_on
);
  logic                        arst_n;
  logic                        ctrl_en, ctrl_open;
  logic [NTIM-1:0][TIME_W-1:0] tim;
  logic [NTHR-1:0][DAC_W-1:0]  thr_hi, thr_lo;
  logic [1:0]                  cmp_s;
  logic                        cur_s, oc_s;
  phase_e                      ph_q, ph_d;
  logic                        hs_q, ls_q;

  phs_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(arst_n));

  phs_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(arst_n), .din({cmp_oc, cmp_cur}), .dout(cmp_s));
  assign cur_s = cmp_s[0];
  assign oc_s  = cmp_s[1];

  phs_regs #(.TIME_W(TIME_W), .DAC_W(DAC_W), .WR_W(WR_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(arst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en(ctrl_en), .open_en(ctrl_open), .tim(tim), .thr_hi(thr_hi), .thr_lo(thr_lo));

  phs_seq #(.TIME_W(TIME_W)) u_seq (
    .clk(clk), .rst_n(arst_n), .en(ctrl_en), .open_en(ctrl_open), .trig(tdc_evt),
    .oc_s(oc_s), .tim(tim), .phase_q(ph_q), .phase_d(ph_d));

  phs_drive #(.DAC_W(DAC_W)) u_drv (
    .clk(clk), .rst_n(arst_n), .phase_q(ph_q), .phase_d(ph_d), .cmp_s(cur_s),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .hs_q(hs_q), .ls_q(ls_q), .dac_q(dac_code));

  assign hs_en_n = ~hs_q;
  assign ls_en_n = ~ls_q;
  assign hs_on   = hs_q;
  assign phase   = ph_q;
endmodule

// File: rtl/phs_checker.sv
module phs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase,
  input logic       hs_en_n,
  input logic       ls_en_n,
  input logic       trig,
  input logic       en,
  input logic       oc_s
);
  import phs_pkg::*;

  // R8: clamp opens both switches from its first cycle
  assert_clamp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLAMP) |-> (hs_en_n && ls_en_n));

  // R8: high side only together with low side
  assert_hs_needs_ls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en_n |-> !ls_en_n);

  // R8: no drive in idle or wait
  assert_idle_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) || (phase == PH_WAIT)) |-> (hs_en_n && ls_en_n));

  // R7: peak starts with the high side on
  assert_peak_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_PEAK) && ($past(phase) != PH_PEAK)) |-> !hs_en_n);

  // R7: hold starts with the high side off
  assert_hold_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_HOLD) && ($past(phase) != PH_HOLD)) |-> hs_en_n);

  // R2: enabled trigger in idle starts the wait
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) && trig && en) |=> (phase == PH_WAIT));

  // R9: synchronized overcurrent in a drive phase forces clamp
  assert_oc_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_s && ((phase == PH_PEAK) || (phase == PH_HOLD) || (phase == PH_OPEN)))
      |=> (phase == PH_CLAMP));

  // R4: clamp leaves only to idle or the opening pulse
  assert_clamp_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLAMP) |=> ((phase == PH_CLAMP) || (phase == PH_IDLE) || (phase == PH_OPEN)));
endmodule

bind ph_solenoid_seq phs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .hs_en_n(hs_en_n), .ls_en_n(ls_en_n),
  .trig(tdc_evt), .en(ctrl_en), .oc_s(oc_s));

// File: tb/tb_ph_solenoid_seq.sv
module tb_ph_solenoid_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        tdc_evt, cmp_cur, cmp_oc;
  logic        hs_en_n, ls_en_n, hs_on;
  logic [7:0]  dac_code;
  logic [2:0]  phase;

  int tests = 0;
  int fails = 0;
  int pcnt [6];
  int seqcode, viol, hsmis;

  always #2 clk = ~clk;

  ph_solenoid_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tdc_evt(tdc_evt), .cmp_cur(cmp_cur), .cmp_oc(cmp_oc), .hs_en_n(hs_en_n),
    .ls_en_n(ls_en_n), .dac_code(dac_code), .phase(phase), .hs_on(hs_on));

  // {wait, peak, hold, clamp, open, open_en} each 8 bits
  localparam logic [47:0] VEC [5] = '{
    {8'd0, 8'd0,  8'd0,  8'd0, 8'd0, 8'd0},
    {8'd5, 8'd4,  8'd9,  8'd3, 8'd6, 8'd1},
    {8'd1, 8'd12, 8'd3,  8'd0, 8'd2, 8'd1},
    {8'd7, 8'd2,  8'd20, 8'd5, 8'd4, 8'd0},
    {8'd0, 8'd1,  8'd1,  8'd1, 8'd0, 8'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int dly, input int pk, input int hd, input int cl,
                     input int op, input int oen);
    wr(1, dly); wr(2, pk); wr(3, hd); wr(4, cl); wr(5, op);
    wr(0, 1 + 2*oen);
  endtask

  // trigger and follow one profile until idle, sampling at negedges
  task automatic run_prof();
    int prev, n, p;
    for (int i = 0; i < 6; i++) pcnt[i] = 0;
    seqcode = 0; viol = 0; hsmis = 0; prev = 0; n = 0;
    @(negedge clk) tdc_evt = 1'b1;
    @(negedge clk) tdc_evt = 1'b0;
    while (n < 5000) begin
      p = int'(phase);
      if (p != prev) begin seqcode = seqcode * 10 + p; prev = p; end
      if (p < 6) pcnt[p]++;
      if (p == 2 || p == 3 || p == 5) begin
        if (ls_en_n !== 1'b0) viol++;
      end else if (hs_en_n !== 1'b1 || ls_en_n !== 1'b1) viol++;
      if (hs_on !== !hs_en_n) hsmis++;
      if (p == 0) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_phase(input int p);
    int n = 0;
    while (int'(phase) != p && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int oseen, nonidle;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    tdc_evt = 1'b0; cmp_cur = 1'b0; cmp_oc = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 phase", int'(phase), 0);
    chk("R1 hs_en_n", int'(hs_en_n), 1);
    chk("R1 ls_en_n", int'(ls_en_n), 1);
    chk("R1 dac", int'(dac_code), 0);
    chk("R1 hs_on", int'(hs_on), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", int'(phase), 0);

    wr(6, 16'h7080);   // peak: lo 0x70, hi 0x80
    wr(7, 16'h3040);   // hold: lo 0x30, hi 0x40
    wr(8, 16'h1020);   // opening: lo 0x10, hi 0x20

    // table of profiles
    foreach (VEC[i]) begin
      int dly, pk, hd, cl, op, oen;
      dly = int'(VEC[i][47:40]); pk = int'(VEC[i][39:32]); hd = int'(VEC[i][31:24]);
      cl  = int'(VEC[i][23:16]); op = int'(VEC[i][15:8]);  oen = int'(VEC[i][7:0]);
      cfg(dly, pk, hd, cl, op, oen);
      run_prof();
      chk("R3 wait cycles", pcnt[1], dly + 1);
      chk("R4 peak cycles", pcnt[2], pk + 1);
      chk("R4 hold cycles", pcnt[3], hd + 1);
      chk("R4 R5 clamp cycles", pcnt[4], (cl + 1) * (oen ? 2 : 1));
      chk("R5 opening cycles", pcnt[5], oen ? op + 1 : 0);
      chk("R4 R5 phase order", seqcode, oen ? 1234540 : 12340);
      chk("R8 switch enables per phase", viol, 0);
      chk("R11 hs_on tracks hs_en_n", hsmis, 0);
      repeat (3) @(negedge clk);
    end

    // directed: regulation, synchronizer latency, overcurrent
    cfg(2, 10, 200, 3, 5, 1);
    @(negedge clk) tdc_evt = 1'b1;
    @(negedge clk) tdc_evt = 1'b0;
    wait_phase(2);
    chk("R7 peak entry hs on", int'(hs_en_n), 0);
    chk("R6 peak upper code", int'(dac_code), 8'h80);
    chk("R8 peak ls on", int'(ls_en_n), 0);
    chk("R11 peak code", int'(phase), 2);
    wait_phase(3);
    chk("R7 hold entry hs off", int'(hs_en_n), 1);
    chk("R6 hold lower code", int'(dac_code), 8'h30);
    repeat (2) @(negedge clk);
    chk("R6 hs on when current low", int'(hs_en_n), 0);
    chk("R6 hold upper code", int'(dac_code), 8'h40);
    cmp_cur = 1'b1;
    @(negedge clk);
    chk("R10 no change after 1 edge", int'(hs_en_n), 0);
    @(negedge clk);
    chk("R10 no change after 2 edges", int'(hs_en_n), 0);
    @(negedge clk);
    chk("R10 R6 hs off after 3 edges", int'(hs_en_n), 1);
    chk("R6 lower code when off", int'(dac_code), 8'h30);
    chk("R11 hs_on low", int'(hs_on), 0);
    repeat (3) @(negedge clk);
    chk("R6 stays off while current high", int'(hs_en_n), 1);
    cmp_cur = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 hs back on", int'(hs_en_n), 0);
    chk("R11 hs_on high", int'(hs_on), 1);
    // overcurrent in hold
    cmp_oc = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 still hold after 2 edges", int'(phase), 3);
    @(negedge clk);
    chk("R9 clamp after 3 edges", int'(phase), 4);
    chk("R8 clamp hs off", int'(hs_en_n), 1);
    chk("R8 clamp ls off", int'(ls_en_n), 1);
    cmp_oc = 1'b0;
    oseen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (int'(phase) == 5) oseen++;
    end
    chk("R9 opening pulse cancelled", oseen, 0);
    chk("R9 back to idle", int'(phase), 0);

    // trigger ignored when disabled
    wr(0, 0);
    @(negedge clk) tdc_evt = 1'b1;
    @(negedge clk) tdc_evt = 1'b0;
    nonidle = 0;
    for (int k = 0; k < 20; k++) begin
      if (int'(phase) != 0 || ls_en_n !== 1'b1) nonidle++;
      @(negedge clk);
    end
    chk("R2 disabled trigger ignored", nonidle, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule